// File: doc/BRIEF.md
# PCI Host Bridge Register Bank with Hard-Fail Policy

This block is the 64-bit register bank of a PCI host bridge, reached from the processor through a simple register bus. A request is a single-cycle valid pulse with a write flag, an access size of 4 or 8 bytes, a byte address and 64 bits of write data. The matching response comes exactly one cycle later. It carries read data and an error flag.

The decoder looks at the address in 8-byte words. The bank holds four kinds of register:
- constant and derived words: a fixed function-class value and a bus-number word built from an input pin;
- three plain read/write registers: arbitration mask, status/control and error configuration;
- a ten-entry array of MMIO window base/mask registers;
- a few write sinks.

A 4-byte access works on one half of a 64-bit register, and address bit 2 selects which half. An access that matches no register falls to a policy chosen by bit 0 of status/control:
- bit set: a read answers zero and a decode error;
- bit clear: a read answers all-ones and no error.

Top module: `pcib_csr_bank`

## Requirements
- R1: Address bits [2:0] play no part in choosing a register. An 8-byte access moves all 64 bits. A 4-byte access moves the upper half when address bit 2 is 1 and the lower half when it is 0, and read data of a 4-byte access appears in rsp_rdata[31:0] with bits [63:32] zero.
- R2: A 4-byte write takes only wdata[31:0] into the selected half and leaves the other half of the register unchanged.
- R3: A read of byte offset 0x008 returns 0x6000005. A read of 0x058 returns bus_num in bits [7:0], bus_num again in bits [15:8], and zero elsewhere.
- R4: Offsets 0x080 (arbitration mask), 0x108 (status/control) and 0x680 (error configuration) read back what was written. A read of 0x688 always returns 0 with no error.
- R5: Offsets 0x200 to 0x24F are ten 64-bit window registers, entry (addr-0x200)/8. Their reset values, entries 0 to 9, are:
  - 0xF0000001, 0xF8000000
  - 0xF800000001, 0xFF80000000
  - 0xF0000001, 0xF0000000
  - 0xF800000001, 0xFC00000000
  - IO_BASE_RST (default 0x1), IO_MASK_RST (default 0xE000)
- R6: Writes to 0x000, 0x300 and 0x308 complete without error and change nothing. Reads of those offsets are treated as unmapped.
- R7: A read that hits no register returns data 0 and rsp_err=1 when status/control bit 0 is 1. When that bit is 0 it returns all-ones and rsp_err=0; for a 4-byte access, all-ones is 0x00000000FFFFFFFF.
- R8: A write that hits no register, including writes to the read-only offsets 0x008, 0x058 and 0x688, changes no register. Its response has rsp_err equal to status/control bit 0 and rsp_rdata 0.
- R9: req_ready is always 1. rsp_valid is 1 exactly in the cycle after each cycle with req_valid=1, and a write is visible to the next request.
- R10: Reset returns status/control, arbitration mask and error configuration to 0, so hard-fail starts disabled. It also returns the window array to its R5 values and clears the response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_num | input | 8 | Bus number of this bridge, shown in the bus-number word |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_ready | output | 1 | Always 1: every request is taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size8 | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| req_addr | input | ADDR_W (13) | Byte address inside the bank |
| req_wdata | input | 64 | Write data (a 4-byte write uses bits [31:0]) |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 64 | Read data (0 for writes) |
| rsp_err | output | 1 | Decode error under the hard-fail policy |

## Verification
The assertions assume that:
- req_size8, req_we and req_addr are stable and meaningful in every cycle that req_valid is high;
- no request is issued while rst_n is low.

The stimulus meets this by driving every field on the falling edge, holding it for one full cycle with req_valid high, and then dropping req_valid before the next request. Bus numbers and addresses are fixed per test, so each response depends only on the prior register contents and the hard-fail bit in force when the request was taken.

// File: rtl/pcib_csr_pkg.sv
package pcib_csr_pkg;

   localparam int DATA_W = 64;
   localparam int HALF_W = DATA_W / 2;
   localparam int HF_BIT = 0;

   // 8-byte word indices of the decoded locations
   localparam int W_SINK0   = 'h000 >> 3;
   localparam int W_CLASS   = 'h008 >> 3;
   localparam int W_BUSNUM  = 'h058 >> 3;
   localparam int W_ARB     = 'h080 >> 3;
   localparam int W_STAT    = 'h108 >> 3;
   localparam int W_WIN0    = 'h200 >> 3;
   localparam int W_SINK1   = 'h300 >> 3;
   localparam int W_SINK2   = 'h308 >> 3;
   localparam int W_ERRCFG  = 'h680 >> 3;
   localparam int W_ERRSTAT = 'h688 >> 3;

   localparam logic [DATA_W-1:0] FUNC_CLASS_VAL = 64'h0000_0000_0600_0005;

   typedef enum logic [3:0] {
      CSR_NONE,
      CSR_CLASS,
      CSR_BUSNUM,
      CSR_ARB,
      CSR_STAT,
      CSR_WIN,
      CSR_ERRCFG,
      CSR_ERRSTAT,
      CSR_SINK
   } csr_kind_e;

   // Place write data into a register, one half or the whole word
   function automatic logic [DATA_W-1:0] merge_half(
      input logic [DATA_W-1:0] old_v,
      input logic [DATA_W-1:0] wd,
      input logic              size8,
      input logic              hi);
      if (size8)   return wd;
      else if (hi) return {wd[HALF_W-1:0], old_v[HALF_W-1:0]};
      else         return {old_v[DATA_W-1:HALF_W], wd[HALF_W-1:0]};
   endfunction

   // Shape a 64-bit value for return on the bus
   function automatic logic [DATA_W-1:0] shape_read(
      input logic [DATA_W-1:0] v,
      input logic              size8,
      input logic              hi);
      if (size8)   return v;
      else if (hi) return {{HALF_W{1'b0}}, v[DATA_W-1:HALF_W]};
      else         return {{HALF_W{1'b0}}, v[HALF_W-1:0]};
   endfunction

endpackage

// File: rtl/pcib_csr_decode.sv
module pcib_csr_decode
   import pcib_csr_pkg::*;
#(
   parameter int WA_W  = 10,
   parameter int WIN_N = 10,
   parameter int IDX_W = 4
) (
   input  logic [WA_W-1:0]  word,
   output csr_kind_e        kind,
   output logic [IDX_W-1:0] idx,
   output logic             rd_hit,
   output logic             wr_hit
);

   localparam logic [WA_W-1:0] A_SINK0   = WA_W'(W_SINK0);
   localparam logic [WA_W-1:0] A_CLASS   = WA_W'(W_CLASS);
   localparam logic [WA_W-1:0] A_BUSNUM  = WA_W'(W_BUSNUM);
   localparam logic [WA_W-1:0] A_ARB     = WA_W'(W_ARB);
   localparam logic [WA_W-1:0] A_STAT    = WA_W'(W_STAT);
   localparam logic [WA_W-1:0] A_WIN0    = WA_W'(W_WIN0);
   localparam logic [WA_W-1:0] A_WINEND  = WA_W'(W_WIN0 + WIN_N);
   localparam logic [WA_W-1:0] A_SINK1   = WA_W'(W_SINK1);
   localparam logic [WA_W-1:0] A_SINK2   = WA_W'(W_SINK2);
   localparam logic [WA_W-1:0] A_ERRCFG  = WA_W'(W_ERRCFG);
   localparam logic [WA_W-1:0] A_ERRSTAT = WA_W'(W_ERRSTAT);

   logic [WA_W-1:0] win_off;
   assign win_off = word - A_WIN0;
   assign idx     = IDX_W'(win_off);

   always_comb begin
      if (word >= A_WIN0 && word < A_WINEND)               kind = CSR_WIN;
      else if (word == A_CLASS)                            kind = CSR_CLASS;
      else if (word == A_BUSNUM)                           kind = CSR_BUSNUM;
      else if (word == A_ARB)                              kind = CSR_ARB;
      else if (word == A_STAT)                             kind = CSR_STAT;
      else if (word == A_ERRCFG)                           kind = CSR_ERRCFG;
      else if (word == A_ERRSTAT)                          kind = CSR_ERRSTAT;
      else if (word == A_SINK0 || word == A_SINK1 ||
               word == A_SINK2)                            kind = CSR_SINK;
      else                                                 kind = CSR_NONE;
   end

   always_comb begin
      rd_hit = 1'b0;
      wr_hit = 1'b0;
      unique case (kind)
         CSR_CLASS, CSR_BUSNUM, CSR_ERRSTAT:     rd_hit = 1'b1;
         CSR_ARB, CSR_STAT, CSR_WIN, CSR_ERRCFG: begin
            rd_hit = 1'b1;
            wr_hit = 1'b1;
         end
         CSR_SINK:                               wr_hit = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/pcib_csr_store.sv
module pcib_csr_store
   import pcib_csr_pkg::*;
#(
   parameter int              WIN_N       = 10,
   parameter int              IDX_W       = 4,
   parameter int              BUSN_W      = 8,
   parameter logic [63:0]     IO_BASE_RST = 64'h1,
   parameter logic [63:0]     IO_MASK_RST = 64'hE000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  csr_kind_e         kind,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic              size8,
   input  logic              hi,
   input  logic [BUSN_W-1:0] bus_num,
   output logic [DATA_W-1:0] rd_val,
   output logic              hf_en
);

   function automatic logic [DATA_W-1:0] win_init(input int i);
      case (i)
         0:       return 64'h0000_0000_F000_0001;
         1:       return 64'h0000_0000_F800_0000;
         2:       return 64'h0000_00F8_0000_0001;
         3:       return 64'h0000_00FF_8000_0000;
         4:       return 64'h0000_0000_F000_0001;
         5:       return 64'h0000_0000_F000_0000;
         6:       return 64'h0000_00F8_0000_0001;
         7:       return 64'h0000_00FC_0000_0000;
         8:       return IO_BASE_RST;
         9:       return IO_MASK_RST;
         default: return '0;
      endcase
   endfunction

   logic [DATA_W-1:0] arb_q, stat_q, ecfg_q;
   logic [DATA_W-1:0] win_q [WIN_N];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arb_q  <= '0;
         stat_q <= '0;
         ecfg_q <= '0;
      end else if (wr_en) begin
         if (kind == CSR_ARB)    arb_q  <= merge_half(arb_q,  wdata, size8, hi);
         if (kind == CSR_STAT)   stat_q <= merge_half(stat_q, wdata, size8, hi);
         if (kind == CSR_ERRCFG) ecfg_q <= merge_half(ecfg_q, wdata, size8, hi);
      end
   end

   for (genvar g = 0; g < WIN_N; g++) begin : g_win
      always_ff @(posedge clk) begin
         if (!rst_n)
            win_q[g] <= win_init(g);
         else if (wr_en && kind == CSR_WIN && idx == IDX_W'(g))
            win_q[g] <= merge_half(win_q[g], wdata, size8, hi);
      end
   end

   logic [DATA_W-1:0] bus_word;
   assign bus_word = DATA_W'(bus_num) | (DATA_W'(bus_num) << BUSN_W);

   always_comb begin
      unique case (kind)
         CSR_CLASS:  rd_val = FUNC_CLASS_VAL;
         CSR_BUSNUM: rd_val = bus_word;
         CSR_ARB:    rd_val = arb_q;
         CSR_STAT:   rd_val = stat_q;
         CSR_ERRCFG: rd_val = ecfg_q;
         CSR_WIN:    rd_val = (int'(idx) < WIN_N) ? win_q[idx] : '0;
         default:    rd_val = '0;
      endcase
   end

   assign hf_en = stat_q[HF_BIT];

   assert_keep_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && kind == CSR_ARB && !size8 && !hi)
      |=> arb_q[DATA_W-1:HALF_W] == $past(arb_q[DATA_W-1:HALF_W]));

   assert_keep_lower_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && kind == CSR_ERRCFG && !size8 && hi)
      |=> ecfg_q[HALF_W-1:0] == $past(ecfg_q[HALF_W-1:0]));

   assert_stat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && kind == CSR_STAT) |=> $stable(stat_q));

endmodule

// File: rtl/pcib_csr_resp.sv
module pcib_csr_resp
   import pcib_csr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_we,
   input  logic              size8,
   input  logic              hi,
   input  logic              rd_hit,
   input  logic              wr_hit,
   input  logic              hf_en,
   input  logic [DATA_W-1:0] rd_val,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err
);

   logic              miss;
   logic [DATA_W-1:0] miss_val;

   assign miss     = req_we ? !wr_hit : !rd_hit;
   assign miss_val = hf_en ? '0 : shape_read('1, size8, hi);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_err <= miss && hf_en;
            if (req_we)       rsp_rdata <= '0;
            else if (!miss)   rsp_rdata <= shape_read(rd_val, size8, hi);
            else              rsp_rdata <= miss_val;
         end
      end
   end

   assert_miss_hardfail_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_we && !rd_hit && hf_en)
      |=> rsp_err && rsp_rdata == '0);

   assert_miss_soft_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_we && !rd_hit && !hf_en && size8)
      |=> !rsp_err && rsp_rdata == '1);

   assert_err_needs_hf_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> $past(hf_en));

endmodule

// File: rtl/pcib_csr_bank.sv
module pcib_csr_bank
   import pcib_csr_pkg::*;
#(
   parameter int          ADDR_W      = 13,
   parameter int          WIN_N       = 10,
   parameter int          BUSN_W      = 8,
   parameter logic [63:0] IO_BASE_RST = 64'h1,
   parameter logic [63:0] IO_MASK_RST = 64'hE000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BUSN_W-1:0] bus_num,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic              req_size8,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [63:0]       req_wdata,
   output logic              rsp_valid,
   output logic [63:0]       rsp_rdata,
   output logic              rsp_err
);

   localparam int WA_W  = ADDR_W - 3;
   localparam int IDX_W = (WIN_N > 1) ? $clog2(WIN_N) : 1;

   if (ADDR_W < 12) begin : g_chk_addr
      $error("ADDR_W must reach offset 0x688");
   end
   if (WIN_N < 1 || WIN_N > 32) begin : g_chk_win
      $error("WIN_N must fit between 0x200 and 0x300");
   end
   if (BUSN_W < 1 || BUSN_W > 32) begin : g_chk_bus
      $error("BUSN_W must be 1 to 32");
   end

   logic              unused_lo;
   logic              hi;
   csr_kind_e         kind;
   logic [IDX_W-1:0]  idx;
   logic              rd_hit, wr_hit, hf_en;
   logic [DATA_W-1:0] rd_val;

   assign unused_lo = ^req_addr[1:0];
   assign hi        = req_addr[2];
   assign req_ready = 1'b1;

   pcib_csr_decode #(.WA_W(WA_W), .WIN_N(WIN_N), .IDX_W(IDX_W)) decode_i (
      .word   (req_addr[ADDR_W-1:3]),
      .kind   (kind),
      .idx    (idx),
      .rd_hit (rd_hit),
      .wr_hit (wr_hit)
   );

   pcib_csr_store #(
      .WIN_N(WIN_N), .IDX_W(IDX_W), .BUSN_W(BUSN_W),
      .IO_BASE_RST(IO_BASE_RST), .IO_MASK_RST(IO_MASK_RST)
   ) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (req_valid && req_we && wr_hit),
      .kind    (kind),
      .idx     (idx),
      .wdata   (req_wdata),
      .size8   (req_size8),
      .hi      (hi),
      .bus_num (bus_num),
      .rd_val  (rd_val),
      .hf_en   (hf_en)
   );

   pcib_csr_resp resp_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_we    (req_we),
      .size8     (req_size8),
      .hi        (hi),
      .rd_hit    (rd_hit),
      .wr_hit    (wr_hit),
      .hf_en     (hf_en),
      .rd_val    (rd_val),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata),
      .rsp_err   (rsp_err)
   );

   assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_rsp_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   assert_class_const_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_we && req_size8 && kind == CSR_CLASS)
      |=> rsp_rdata == FUNC_CLASS_VAL && !rsp_err);

   assert_errstat_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_we && kind == CSR_ERRSTAT)
      |=> rsp_rdata == '0 && !rsp_err);

endmodule

// File: tb/pcib_csr_bank_tb.sv
`timescale 1ns/100ps
module pcib_csr_bank_tb_top;

   localparam int VW = 148;
   localparam int NV = 44;
   localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
   localparam logic [63:0] LO1  = 64'h0000_0000_FFFF_FFFF;

   // {req[3:0], we, size8, addr[12:0], wdata[63:0], exp[63:0], exp_err}
   localparam logic [VW-1:0] VEC [NV] = '{
      {4'd3,  1'b0,1'b1,13'h008, 64'h0, 64'h6000005, 1'b0},           // R3
      {4'd1,  1'b0,1'b0,13'h00C, 64'h0, 64'h0, 1'b0},                 // R1
      {4'd1,  1'b0,1'b0,13'h00A, 64'h0, 64'h6000005, 1'b0},           // R1
      {4'd3,  1'b0,1'b1,13'h058, 64'h0, 64'h2A2A, 1'b0},              // R3
      {4'd5,  1'b0,1'b1,13'h200, 64'h0, 64'hF0000001, 1'b0},          // R5
      {4'd5,  1'b0,1'b1,13'h208, 64'h0, 64'hF8000000, 1'b0},          // R5
      {4'd5,  1'b0,1'b1,13'h210, 64'h0, 64'hF800000001, 1'b0},        // R5
      {4'd5,  1'b0,1'b1,13'h218, 64'h0, 64'hFF80000000, 1'b0},        // R5
      {4'd5,  1'b0,1'b1,13'h220, 64'h0, 64'hF0000001, 1'b0},          // R5
      {4'd5,  1'b0,1'b1,13'h228, 64'h0, 64'hF0000000, 1'b0},          // R5
      {4'd5,  1'b0,1'b1,13'h230, 64'h0, 64'hF800000001, 1'b0},        // R5
      {4'd1,  1'b0,1'b0,13'h23C, 64'h0, 64'hFC, 1'b0},                // R1
      {4'd5,  1'b0,1'b1,13'h240, 64'h0, 64'h1, 1'b0},                 // R5
      {4'd5,  1'b0,1'b1,13'h24F, 64'h0, 64'hE000, 1'b0},              // R5
      {4'd7,  1'b0,1'b1,13'h250, 64'h0, ONES, 1'b0},                  // R7
      {4'd4,  1'b1,1'b1,13'h080, 64'h1122334455667788, 64'h0, 1'b0},  // R4
      {4'd2,  1'b1,1'b0,13'h084, 64'h00000000AABBCCDD, 64'h0, 1'b0},  // R2
      {4'd2,  1'b0,1'b1,13'h083, 64'h0, 64'hAABBCCDD55667788, 1'b0},  // R2
      {4'd2,  1'b1,1'b0,13'h080, 64'hFFFFFFFF00000042, 64'h0, 1'b0},  // R2
      {4'd2,  1'b0,1'b1,13'h080, 64'h0, 64'hAABBCCDD00000042, 1'b0},  // R2
      {4'd1,  1'b0,1'b0,13'h084, 64'h0, 64'hAABBCCDD, 1'b0},          // R1
      {4'd4,  1'b1,1'b0,13'h680, 64'hCAFEF00D, 64'h0, 1'b0},          // R4
      {4'd4,  1'b0,1'b1,13'h680, 64'h0, 64'hCAFEF00D, 1'b0},          // R4
      {4'd4,  1'b0,1'b1,13'h688, 64'h0, 64'h0, 1'b0},                 // R4
      {4'd6,  1'b1,1'b1,13'h300, 64'h5, 64'h0, 1'b0},                 // R6
      {4'd6,  1'b1,1'b1,13'h308, 64'h6, 64'h0, 1'b0},                 // R6
      {4'd6,  1'b0,1'b1,13'h300, 64'h0, ONES, 1'b0},                  // R6
      {4'd8,  1'b1,1'b1,13'h008, 64'h99, 64'h0, 1'b0},                // R8
      {4'd8,  1'b0,1'b1,13'h008, 64'h0, 64'h6000005, 1'b0},           // R8
      {4'd5,  1'b1,1'b1,13'h248, 64'h123, 64'h0, 1'b0},               // R5
      {4'd5,  1'b0,1'b1,13'h248, 64'h0, 64'h123, 1'b0},               // R5
      {4'd7,  1'b1,1'b0,13'h10C, 64'h1, 64'h0, 1'b0},                 // R7
      {4'd7,  1'b0,1'b0,13'h404, 64'h0, LO1, 1'b0},                   // R7
      {4'd7,  1'b1,1'b0,13'h108, 64'h1, 64'h0, 1'b0},                 // R7
      {4'd7,  1'b0,1'b1,13'h400, 64'h0, 64'h0, 1'b1},                 // R7
      {4'd7,  1'b0,1'b0,13'h404, 64'h0, 64'h0, 1'b1},                 // R7
      {4'd8,  1'b1,1'b1,13'h058, 64'h77, 64'h0, 1'b1},                // R8
      {4'd8,  1'b0,1'b1,13'h058, 64'h0, 64'h2A2A, 1'b0},              // R8
      {4'd6,  1'b1,1'b1,13'h000, 64'h3, 64'h0, 1'b0},                 // R6
      {4'd6,  1'b0,1'b1,13'h300, 64'h0, 64'h0, 1'b1},                 // R6
      {4'd4,  1'b0,1'b1,13'h108, 64'h0, 64'h0000000100000001, 1'b0},  // R4
      {4'd7,  1'b1,1'b1,13'h108, 64'h0, 64'h0, 1'b0},                 // R7
      {4'd7,  1'b0,1'b1,13'h1FF8, 64'h0, ONES, 1'b0},                 // R7
      {4'd8,  1'b1,1'b1,13'h1FF8, 64'h1, 64'h0, 1'b0}                 // R8
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_num = 8'h2A;
   logic        req_valid = 1'b0, req_we = 1'b0, req_size8 = 1'b0;
   logic [12:0] req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic        req_ready, rsp_valid, rsp_err;
   logic [63:0] rsp_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pcib_csr_bank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_num(bus_num),
      .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
      .req_size8(req_size8), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
   );

   task automatic check(input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive at falling edge, sample at the next falling edge
   task automatic access(input logic we, input logic sz8, input logic [12:0] a,
                         input logic [63:0] wd, output logic [63:0] rd,
                         output logic err, output logic vld);
      @(negedge clk);
      req_valid = 1'b1; req_we = we; req_size8 = sz8;
      req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      rd = rsp_rdata; err = rsp_err; vld = rsp_valid;
   endtask

   initial begin
      logic [63:0] rd;
      logic        er, vl;
      repeat (3) @(negedge clk);
      check("R10 rsp_valid in reset", {63'b0, rsp_valid}, 64'h0);
      check("R10 rsp_err in reset", {63'b0, rsp_err}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 req_ready", {63'b0, req_ready}, 64'h1);
      check("R9 idle rsp_valid", {63'b0, rsp_valid}, 64'h0);
      access(1'b0, 1'b1, 13'h108, 64'h0, rd, er, vl);
      check("R10 status reset", rd, 64'h0);
      check("R9 rsp_valid after request", {63'b0, vl}, 64'h1);
      access(1'b0, 1'b1, 13'h080, 64'h0, rd, er, vl);
      check("R10 arb reset", rd, 64'h0);
      access(1'b0, 1'b1, 13'h680, 64'h0, rd, er, vl);
      check("R10 errcfg reset", rd, 64'h0);
      @(negedge clk);
      check("R9 rsp_valid drops", {63'b0, rsp_valid}, 64'h0);

      for (int i = 0; i < NV; i++) begin
         logic [VW-1:0] v;
         string tag;
         v = VEC[i];
         access(v[143], v[142], v[141:129], v[128:65], rd, er, vl);
         tag = $sformatf("vec %0d R%0d", i, v[147:144]);
         check({tag, " valid"}, {63'b0, vl}, 64'h1);
         check({tag, " err"}, {63'b0, er}, {63'b0, v[0]});
         check({tag, " data"}, rd, v[143] ? 64'h0 : v[64:1]);
      end

      // reset in the middle of a run restores every register (R10)
      access(1'b1, 1'b1, 13'h080, 64'h55, rd, er, vl);
      access(1'b1, 1'b1, 13'h200, 64'h77, rd, er, vl);
      access(1'b1, 1'b1, 13'h108, 64'h1, rd, er, vl);
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      access(1'b0, 1'b1, 13'h080, 64'h0, rd, er, vl);
      check("R10 arb after re-reset", rd, 64'h0);
      access(1'b0, 1'b1, 13'h200, 64'h0, rd, er, vl);
      check("R10 window after re-reset", rd, 64'hF0000001);
      access(1'b0, 1'b0, 13'h600, 64'h0, rd, er, vl);
      check("R10 hard-fail off after reset", {er, rd[62:0]}, {1'b0, 63'hFFFFFFFF});

      // 8-byte access with bit 2 set still moves the full word (R1)
      access(1'b1, 1'b1, 13'h684, 64'h0123456789ABCDEF, rd, er, vl);
      access(1'b0, 1'b1, 13'h680, 64'h0, rd, er, vl);
      check("R1 8-byte at bit2", rd, 64'h0123456789ABCDEF);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R9 actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule